// File: doc/BRIEF.md
# Store Queue with Read Forwarding

This block holds the stores of a write-through data cache on their way to main memory. Each accepted store is kept as an address/data pair in a small circular queue. A drain path, running on its own, sends the oldest entry to memory over a single request/acknowledge port. The processor stalls only when every slot is taken.

A read miss is serviced through the same block. In the default mode the read address is compared against every occupied slot in the same cycle. If a slot matches, the newest matching data is returned at once and memory is not touched. If nothing matches, the read takes the memory port ahead of any write that has not yet started. Any transaction already under way is always allowed to finish first. Setting `rd_wait_empty` switches to a conservative mode: every read waits until the queue has fully drained and is then served from memory.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset `mem_req`, `rd_done` and `st_stall` are low and the queue is empty.
- R2: A store is accepted on a clock edge where `st_valid` is high and `st_stall` is low. With `DEPTH`=4, four stores are accepted back to back without a stall.
- R3: Accepted stores reach memory as write transactions (`mem_we`=1), each exactly once, in the order they were accepted, with their own address and data.
- R4: `st_stall` is high exactly while all `DEPTH` slots are occupied. A store presented while it is high is held off until a drain completes.
- R5: A store accepted on the same edge as a drain completes leaves the occupancy correct, so no entry is lost or sent twice.
- R6: In forwarding mode, a read whose address matches an occupied slot gets `rd_done`=1 with `rd_fwd`=1 on the edge after `rd_valid` is first seen, and no memory read is issued.
- R7: When several slots match the read address, the data of the most recently accepted matching store is returned.
- R8: A read that matches no slot issues a memory read (`mem_we`=0) as soon as the port is idle, before any queued write that has not started. `rd_done` rises with `rd_fwd`=0 on the edge after `mem_ack`, carrying `mem_rdata`.
- R9: With `rd_wait_empty`=1, a read is issued to memory only once the queue is empty, and it never takes data from a slot.
- R10: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the edge on which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_wait_empty | input | 1 | 1: reads wait for an empty queue; 0: reads forward from slots |
| st_valid | input | 1 | Store present |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_stall | output | 1 | Queue full, store not taken |
| rd_valid | input | 1 | Read miss request, held until `rd_done` |
| rd_addr | input | ADDR_W | Read address |
| rd_done | output | 1 | One-cycle read completion pulse |
| rd_data | output | DATA_W | Read result, valid with `rd_done` |
| rd_fwd | output | 1 | Result came from a slot rather than memory |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Transaction completes on this edge |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |

## Verification
A forwarded read completes one edge after `rd_valid` is first seen. A memory read raises `mem_req` one edge after the port goes idle and completes one edge after `mem_ack`. A drain starts one edge after the entry is present and the port is idle. The bench samples every output on the falling edge. Read tasks count the falling edges until `rd_done`, so the one-cycle forwarding latency is checked exactly, while memory-served reads are checked only for value, source and the number of writes still queued when the read completes. The memory model acknowledges after a programmable delay, and a monitor pops expected writes from a scoreboard queue on every acknowledged write.

// File: rtl/wbuf_bypass.sv
module wbuf_bypass #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_wait_empty,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_stall,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_fwd,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] slot_addr [DEPTH];
  logic [DATA_W-1:0] slot_data [DEPTH];
  logic [PW-1:0]     head, tail;
  logic [CW-1:0]     count;

  logic              busy, busy_rd;
  logic [ADDR_W-1:0] out_addr;
  logic [DATA_W-1:0] out_data;

  logic              hit;
  logic [DATA_W-1:0] hit_data;
  logic [PW-1:0]     idx;

  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    idx      = head;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PW'(k);
      if (CW'(k) < count && slot_addr[idx] == rd_addr) begin
        hit      = 1'b1;
        hit_data = slot_data[idx];
      end
    end
  end

  logic full, push, pop, done_mem, rd_want, fwd_now, rd_go, wr_go;

  assign full     = (count == CW'(DEPTH));
  assign push     = st_valid && !full;
  assign done_mem = busy && mem_ack;
  assign pop      = done_mem && !busy_rd;
  assign rd_want  = rd_valid && !rd_done && !(busy && busy_rd);
  assign fwd_now  = rd_want && !rd_wait_empty && hit;
  assign rd_go    = rd_want && !busy && (rd_wait_empty ? (count == '0) : !hit);
  assign wr_go    = !busy && !rd_go && (count != '0);

  always_ff @(posedge clk) begin
    if (push) begin
      slot_addr[tail] <= st_addr;
      slot_data[tail] <= st_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= tail + 1'b1;
      if (pop)  head <= head + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      busy_rd  <= 1'b0;
      out_addr <= '0;
      out_data <= '0;
    end else if (done_mem) begin
      busy <= 1'b0;
    end else if (rd_go) begin
      busy     <= 1'b1;
      busy_rd  <= 1'b1;
      out_addr <= rd_addr;
    end else if (wr_go) begin
      busy     <= 1'b1;
      busy_rd  <= 1'b0;
      out_addr <= slot_addr[head];
      out_data <= slot_data[head];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_done <= 1'b0;
      rd_data <= '0;
      rd_fwd  <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      if (done_mem && busy_rd) begin
        rd_done <= 1'b1;
        rd_data <= mem_rdata;
        rd_fwd  <= 1'b0;
      end else if (fwd_now) begin
        rd_done <= 1'b1;
        rd_data <= hit_data;
        rd_fwd  <= 1'b1;
      end
    end
  end

  assign st_stall  = full;
  assign mem_req   = busy;
  assign mem_we    = busy && !busy_rd;
  assign mem_addr  = out_addr;
  assign mem_wdata = out_data;

endmodule

// File: rtl/wbuf_bypass_chk.sv
module wbuf_bypass_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_wait_empty,
  input logic              st_valid,
  input logic              st_stall,
  input logic              rd_done,
  input logic              rd_fwd,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] occ;
  logic          in_p, out_p;

  assign in_p  = st_valid && !st_stall;
  assign out_p = mem_req && mem_ack && mem_we;

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else if (in_p && !out_p) occ <= occ + 1'b1;
    else if (out_p && !in_p) occ <= occ - 1'b1;
  end

  assert_stall_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_stall == (occ == CW'(DEPTH)));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (occ != '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);

  assert_fwd_no_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && rd_fwd) |-> !$past(mem_req && mem_ack && !mem_we));

  assert_mem_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !rd_fwd) |-> $past(mem_req && mem_ack && !mem_we));

  assert_wait_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req) && !mem_we && rd_wait_empty) |-> ($past(occ) == '0));

  assert_wait_nofwd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && rd_wait_empty) |-> !rd_fwd);

endmodule

bind wbuf_bypass wbuf_bypass_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_wait_empty(rd_wait_empty), .st_valid(st_valid),
  .st_stall(st_stall), .rd_done(rd_done), .rd_fwd(rd_fwd), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/tb_wbuf_bypass.sv
module tb_wbuf_bypass;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_wait_empty = 1'b0;
  logic          st_valid = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic          st_stall;
  logic          rd_valid = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_done;
  logic [DW-1:0] rd_data;
  logic          rd_fwd;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wbuf_bypass #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .rd_wait_empty(rd_wait_empty),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_stall(st_stall),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data), .rd_fwd(rd_fwd),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int fails = 0;
  int lat = 0;
  int lat_cnt = 0;
  int wr_acked = 0;
  int rd_tx = 0;
  int pend_at_rd = -1;
  int stall_cycles = 0;
  logic [AW-1:0] exp_a [$];
  logic [DW-1:0] exp_d [$];
  logic [DW-1:0] bmem [logic [AW-1:0]];
  logic [DW-1:0] shadow [logic [AW-1:0]];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // memory model and write scoreboard monitor
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      lat_cnt = 0;
    end else if (mem_req) begin
      if (lat_cnt >= lat) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          if (exp_a.size() == 0) begin
            chk(1'b0, "R5 unexpected write", mem_addr, 0);
          end else begin
            chk(mem_addr == exp_a[0] && mem_wdata == exp_d[0], "R3 write order", mem_wdata, exp_d[0]);
            void'(exp_a.pop_front());
            void'(exp_d.pop_front());
          end
          bmem[mem_addr] = mem_wdata;
          wr_acked++;
        end else begin
          mem_rdata = bmem.exists(mem_addr) ? bmem[mem_addr] : '0;
          pend_at_rd = exp_a.size();
          rd_tx++;
        end
      end else begin
        lat_cnt++;
      end
    end
  end

  task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    st_valid = 1'b1;
    st_addr  = a;
    st_data  = d;
    while (st_stall) begin
      stall_cycles++;
      @(negedge clk);
    end
    @(negedge clk);
    st_valid = 1'b0;
    exp_a.push_back(a);
    exp_d.push_back(d);
    shadow[a] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit exp_fwd, input string req, output int cyc);
    logic [DW-1:0] e;
    e = shadow.exists(a) ? shadow[a] : '0;
    rd_valid = 1'b1;
    rd_addr  = a;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!rd_done);
    rd_valid = 1'b0;
    chk(rd_data == e, req, rd_data, e);
    chk(rd_fwd == exp_fwd, req, rd_fwd, exp_fwd);
  endtask

  task automatic drain_all();
    while (exp_a.size() != 0 || mem_req) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cyc;
    int tx0;
    repeat (3) @(negedge clk);
    chk(st_stall == 1'b0, "R1 stall", st_stall, 0);
    chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
    chk(rd_done == 1'b0, "R1 rd_done", rd_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req == 1'b0 && st_stall == 1'b0, "R1 after release", mem_req, 0);

    // burst with fast memory: order and exactly-once
    lat = 0;
    for (int i = 0; i < 8; i++) store(32'h100 + 4*i, 32'h1000 + i);
    drain_all();
    chk(exp_a.size() == 0, "R3 all drained", exp_a.size(), 0);

    // youngest match, forwarding latency, no memory read
    lat = 6;
    store(32'h200, 32'd11);
    store(32'h204, 32'd22);
    store(32'h200, 32'd33);
    tx0 = rd_tx;
    do_read(32'h200, 1'b1, "R7 youngest match", cyc);
    chk(cyc == 1, "R6 forward latency", cyc, 1);
    chk(rd_tx == tx0, "R6 no memory read", rd_tx, tx0);

    // miss jumps ahead of queued writes
    do_read(32'h104, 1'b0, "R8 miss data", cyc);
    chk(pend_at_rd == 2, "R8 read before queued writes", pend_at_rd, 2);
    drain_all();
    do_read(32'h200, 1'b0, "R3 memory holds newest", cyc);

    // full queue stalls
    lat = 20;
    stall_cycles = 0;
    wr_acked = 0;
    for (int i = 0; i < 6; i++) begin
      store(32'h400 + 4*i, 32'h4000 + i);
      if (i == 3) chk(stall_cycles == 0, "R2 four stores without stall", stall_cycles, 0);
      if (i == 4) chk(wr_acked >= 1, "R4 fifth store waits for a drain", wr_acked, 1);
    end
    chk(stall_cycles > 0, "R4 stall seen", stall_cycles, 1);
    drain_all();
    chk(exp_a.size() == 0, "R4 all drained", exp_a.size(), 0);

    // concurrent push and pop
    lat = 0;
    for (int i = 0; i < 20; i++) store(32'h500 + 4*i, 32'h5000 + 3*i);
    drain_all();
    chk(exp_a.size() == 0 && !mem_req, "R5 occupancy consistent", exp_a.size(), 0);
    do_read(32'h54c, 1'b0, "R5 last write landed", cyc);

    // wait-for-empty mode
    rd_wait_empty = 1'b1;
    lat = 4;
    store(32'h300, 32'd77);
    store(32'h304, 32'd88);
    do_read(32'h300, 1'b0, "R9 read after drain", cyc);
    chk(pend_at_rd == 0, "R9 queue empty at read", pend_at_rd, 0);
    do_read(32'h204, 1'b0, "R9 empty-queue read", cyc);
    drain_all();

    finish_run();
  end
endmodule